// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of an interval timer: a down-counter that is as wide as a count word, with three selectable output behaviours. The first is a one-shot terminal-count flag. The second is a rate generator that produces one low pulse per period. The third is a square-wave generator. The counting clock enters as `cnt_tick`, a single-cycle strobe in the `clk` domain. Each strobe stands for one falling edge of the counter clock, and every counter update happens on a strobed cycle. `gate` is a level-sensitive enable.

A host programs the channel through a byte-wide write stream. A control byte selects the mode, or asks for a snapshot of the running count. Data bytes carry the initial count, low byte first. The programmed initial count cannot be read back. Only the snapshot is readable, through a byte-wide read stream.

Write stream rules: `wr_ready` is always high, so a byte transfers on every cycle that `wr_valid` is high, and only one byte can transfer per cycle. Read stream rules: `rd_valid` stays high while the snapshot holds unread bytes. A byte transfers on a cycle where both `rd_valid` and `rd_ready` are high. While `rd_ready` is low, `rd_data` holds still.

Top module: `pit_channel`

## Requirements
- R1: After reset, `out` is low, `rd_valid` is low, `wr_ready` is high, and strobes on `cnt_tick` do not change `out` until the channel has been programmed.
- R2: A control byte with bit 7 clear sets the mode from bits [1:0]: 00 is terminal count, 10 is rate, 11 is square. The code 01 is ignored and has no effect. A valid mode byte stops counting, sets `out` low for terminal count or high for the other two modes, and makes the next data byte the low byte.
- R3: A new count takes effect only after its high byte is written. Both bytes enter the counter together on the next strobe, and decrementing starts on the strobe after that.
- R4: In terminal-count mode, `out` stays low until the counter steps from 1 to 0. It then stays high, while the counter keeps decrementing and wraps to 0xFFFF.
- R5: While `gate` is low, strobes do not decrement the counter in any mode. In terminal-count mode, counting resumes from the held value when `gate` returns high.
- R6: In rate mode with count N, `out` is low for exactly one strobe period when the counter holds 1. The counter then reloads N and `out` returns high, so the period is N strobes.
- R7: In rate mode, a count of 1 keeps `out` high on every cycle.
- R8: In square mode with count N, `out` is high for ceil(N/2) strobes and low for floor(N/2) strobes in every period.
- R9: In rate and square modes, `gate` low forces `out` high in the same cycle. After `gate` rises, the next strobe reloads the full initial count with `out` high.
- R10: A programmed count of 0 counts as 65536 strobes. Its snapshot right after loading reads 0x0000.
- R11: A control byte with bit 7 set copies the counter into the snapshot and leaves the mode untouched. The snapshot is read low byte first. It holds its value until both bytes are read, and further snapshot requests are ignored until then.
- R12: `wr_ready` is always high, and `rd_data` is stable while `rd_valid` is high and `rd_ready` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_tick | input | 1 | One-cycle strobe for each counter-clock falling edge |
| gate | input | 1 | Count enable, level sensitive |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Write byte accepted (always high) |
| wr_ctl | input | 1 | 1 marks a control byte, 0 marks a count byte |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Snapshot byte available |
| rd_ready | input | 1 | Host takes the snapshot byte |
| rd_data | output | 8 | Snapshot byte, low byte first |
| out | output | 1 | Channel output |

## Verification
On every cycle, assertions check the following properties: the terminal-count flag never drops back low, a low gate freezes the counter, rate mode with a count of 1 never goes low, square mode starts each period high, a gate restart reloads the full count, and the snapshot holds still under back-pressure. Other behaviours show only in the bench's scenarios. These are the exact pulse patterns and high/low split for given counts, the atomic two-byte load, the ignored reserved mode, the 65536 count for 0, and the ignored repeat snapshot request.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [1:0] {
    M_TC   = 2'b00,
    M_RSV  = 2'b01,
    M_RATE = 2'b10,
    M_SQ   = 2'b11
  } mode_e;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/pit_host_port.sv
module pit_host_port import pit_pkg::*; #(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_ctl,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_ready,
  input  logic [CW-1:0]     ce_val,
  output logic              cfg_we,
  output mode_e             cfg_mode,
  output logic [CW-1:0]     cr,
  output logic              cr_commit,
  output logic              rd_valid,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int NB = CW / BYTE_W;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IW-1:0] LAST = IW'(NB - 1);

  logic [CW-1:0] stage, stage_nx, snap;
  logic [IW-1:0] widx, ridx;
  logic          latch_req, data_we, rd_fire;

  // a control byte either asks for a snapshot (bit 7) or sets a mode
  assign latch_req = wr_valid & wr_ctl & wr_data[7];
  assign cfg_we    = wr_valid & wr_ctl & ~wr_data[7] & (mode_e'(wr_data[1:0]) != M_RSV);
  assign cfg_mode  = mode_e'(wr_data[1:0]);
  assign data_we   = wr_valid & ~wr_ctl;
  assign rd_fire   = rd_valid & rd_ready;
  assign rd_data   = snap[int'(ridx)*BYTE_W +: BYTE_W];

  always_comb begin
    stage_nx = stage;
    stage_nx[int'(widx)*BYTE_W +: BYTE_W] = wr_data;
  end

  // count assembly: lower bytes are staged, the count register changes only once the full word is in
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage     <= '0;
      cr        <= '0;
      widx      <= '0;
      cr_commit <= 1'b0;
    end else begin
      cr_commit <= 1'b0;
      if (cfg_we) begin
        widx <= '0;
      end else if (data_we) begin
        stage <= stage_nx;
        if (widx == LAST) begin
          cr        <= stage_nx;
          cr_commit <= 1'b1;
          widx      <= '0;
        end else begin
          widx <= widx + 1'b1;
        end
      end
    end
  end

  // snapshot: frozen until every byte has gone out
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap     <= '0;
      ridx     <= '0;
      rd_valid <= 1'b0;
    end else if (rd_valid) begin
      if (rd_fire) begin
        if (ridx == LAST) begin
          rd_valid <= 1'b0;
          ridx     <= '0;
        end else begin
          ridx <= ridx + 1'b1;
        end
      end
    end else if (latch_req) begin
      snap     <= ce_val;
      ridx     <= '0;
      rd_valid <= 1'b1;
    end
  end

  a_r11_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r3_commit_whole: assert property (@(posedge clk) disable iff (!rst_n)
    cr_commit |-> (widx == '0));
endmodule

// File: rtl/pit_count_elem.sv
module pit_count_elem import pit_pkg::*; #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          gate,
  input  logic          cfg_we,
  input  mode_e         cfg_mode,
  input  logic [CW-1:0] cr,
  input  logic          cr_commit,
  output logic [CW-1:0] ce_val,
  output logic          out
);
  localparam int EW = CW + 1;

  mode_e         mode_q;
  logic [EW-1:0] ce, n_eff, half, dec;
  logic          out_q, running, load_pend, gate_q, rst_pend, restart;

  // a count of zero means the full range
  assign n_eff   = (cr == '0) ? {1'b1, {CW{1'b0}}} : {1'b0, cr};
  assign half    = n_eff >> 1;
  assign dec     = (ce == '0) ? {1'b0, {CW{1'b1}}} : ce - 1'b1;
  assign restart = (rst_pend | (gate & ~gate_q)) & (mode_q != M_TC);
  assign ce_val  = ce[CW-1:0];
  assign out     = out_q | ((mode_q != M_TC) & ~gate);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= M_TC;
      ce        <= '0;
      out_q     <= 1'b0;
      running   <= 1'b0;
      load_pend <= 1'b0;
      gate_q    <= 1'b0;
      rst_pend  <= 1'b0;
    end else begin
      gate_q <= gate;
      if (gate & ~gate_q) rst_pend <= 1'b1;
      if (cfg_we) begin
        mode_q    <= cfg_mode;
        out_q     <= (cfg_mode != M_TC);
        running   <= 1'b0;
        load_pend <= 1'b0;
        rst_pend  <= 1'b0;
      end else begin
        if (cr_commit) load_pend <= 1'b1;
        if (tick) begin
          rst_pend <= 1'b0;
          if (load_pend) begin
            ce        <= n_eff;
            running   <= 1'b1;
            load_pend <= 1'b0;
            out_q     <= (mode_q != M_TC);
          end else if (running && restart) begin
            ce    <= n_eff;
            out_q <= 1'b1;
          end else if (running && gate) begin
            case (mode_q)
              M_RATE: begin
                if (ce == EW'(1)) begin
                  ce    <= n_eff;
                  out_q <= 1'b1;
                end else begin
                  ce    <= dec;
                  out_q <= (dec != EW'(1));
                end
              end
              M_SQ: begin
                if (ce == EW'(1)) begin
                  ce    <= n_eff;
                  out_q <= 1'b1;
                end else begin
                  ce    <= dec;
                  out_q <= (dec > half);
                end
              end
              default: begin
                ce <= dec;
                if (ce == EW'(1)) out_q <= 1'b1;
              end
            endcase
          end
        end
      end
    end
  end

  a_r4_tc_flag_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_TC && out_q && !cfg_we && !load_pend) |=> out_q);
  a_r5_gate_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !gate && !load_pend && !rst_pend && !cfg_we) |=> (ce == $past(ce)));
  a_r7_rate_one_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_RATE && running && !load_pend && cr == CW'(1)) |-> out);
  a_r8_sq_period_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SQ && running && tick && gate && !load_pend && !restart && !cfg_we && ce == EW'(1)) |=> out_q);
  a_r9_restart_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && restart && !load_pend && !cfg_we) |=> (ce == $past(n_eff) && out_q));
endmodule

// File: rtl/pit_channel.sv
module pit_channel import pit_pkg::*; #(
  parameter int CW = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cnt_tick,
  input  logic        gate,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic        wr_ctl,
  input  logic [7:0]  wr_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [7:0]  rd_data,
  output logic        out
);
  logic          cfg_we, cr_commit;
  mode_e         cfg_mode;
  logic [CW-1:0] cr, ce_val;

  assign wr_ready = 1'b1;

  pit_host_port #(.CW(CW)) u_host (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ctl(wr_ctl),
    .wr_data(wr_data), .rd_ready(rd_ready), .ce_val(ce_val),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cr(cr), .cr_commit(cr_commit),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  pit_count_elem #(.CW(CW)) u_ce (
    .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .gate(gate),
    .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cr(cr), .cr_commit(cr_commit),
    .ce_val(ce_val), .out(out)
  );

  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(wr_valid && wr_ctl && wr_data[7]));
endmodule

// File: tb/sim_pit_channel.sv
`timescale 1ns/1ps
module sim_pit_channel;
  logic clk = 1'b0, rst_n = 1'b0, cnt_tick = 1'b0, gate = 1'b1;
  logic wr_valid = 1'b0, wr_ctl = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = '0;
  logic wr_ready, rd_valid, out;
  logic [7:0] rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pit_channel u0 (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .gate(gate),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_ctl(wr_ctl), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .out(out)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic ctl, input logic [7:0] d);
    @(negedge clk); wr_valid = 1'b1; wr_ctl = ctl; wr_data = d;
    @(negedge clk); wr_valid = 1'b0; wr_ctl = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); cnt_tick = 1'b1;
    repeat (n) @(negedge clk);
    cnt_tick = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] b);
    @(negedge clk); rd_ready = 1'b1; b = rd_data;
    @(negedge clk); rd_ready = 1'b0;
  endtask

  task automatic snap_read(input string req, input int exp);
    logic [7:0] lo, hi;
    wr(1'b1, 8'h80);
    rd_byte(lo); rd_byte(hi);
    chk(req, {hi, lo}, exp);
  endtask

  task automatic load(input logic [15:0] n);
    wr(1'b0, n[7:0]); wr(1'b0, n[15:8]);
  endtask

  task automatic t_reset();
    chk("R1 out", out, 0); chk("R1 rd_valid", rd_valid, 0); chk("R1 wr_ready", wr_ready, 1);
    ticks(3);
    chk("R1 out after ticks", out, 0);
  endtask

  task automatic t_mode0();
    wr(1'b1, 8'h00);
    chk("R2 tc initial low", out, 0);
    wr(1'b0, 8'd3);
    ticks(2);
    snap_read("R3 no load on low byte", 0);
    wr(1'b0, 8'd0);
    ticks(1);
    snap_read("R3 both bytes loaded", 3);
    ticks(2);
    chk("R4 still low at 1", out, 0);
    ticks(1);
    chk("R4 high at terminal", out, 1);
    ticks(1);
    chk("R4 stays high", out, 1);
    snap_read("R4 wraps", 16'hFFFF);
  endtask

  task automatic t_gate_hold();
    wr(1'b1, 8'h00); load(16'd10); ticks(1); ticks(2);
    gate = 1'b0; ticks(3);
    snap_read("R5 held while gate low", 8);
    gate = 1'b1; ticks(2);
    snap_read("R5 resumes from held", 6);
    chk("R5 out low", out, 0);
  endtask

  task automatic t_rate();
    logic [6:0] exp_pat = 7'b1011011; // index 0 first: H H L H H L H
    wr(1'b1, 8'h02);
    chk("R2 rate initial high", out, 1);
    load(16'd3);
    for (int i = 0; i < 7; i++) begin
      ticks(1);
      chk($sformatf("R6 rate step %0d", i), out, exp_pat[i]);
    end
  endtask

  task automatic t_rsv();
    wr(1'b1, 8'h01);
    chk("R2 reserved mode ignored", out, 1);
  endtask

  task automatic t_rate1();
    int lows = 0;
    wr(1'b1, 8'h02); load(16'd1);
    for (int i = 0; i < 8; i++) begin
      ticks(1);
      if (!out) lows++;
    end
    chk("R7 count one never low", lows, 0);
  endtask

  task automatic t_square(input int n);
    int hi = 0, lo = 0;
    wr(1'b1, 8'h03); load(16'(n)); ticks(1);
    for (int i = 0; i < 2 * n; i++) begin
      ticks(1);
      if (out) hi++; else lo++;
    end
    chk($sformatf("R8 square high n=%0d", n), hi, 2 * ((n + 1) / 2));
    chk($sformatf("R8 square low n=%0d", n), lo, 2 * (n / 2));
  endtask

  task automatic t_gate23();
    wr(1'b1, 8'h03); load(16'd6); ticks(1); ticks(3);
    chk("R9 square low phase", out, 0);
    @(negedge clk); gate = 1'b0; #1;
    chk("R9 gate low forces high", out, 1);
    ticks(2);
    chk("R9 held high", out, 1);
    @(negedge clk); gate = 1'b1;
    ticks(1);
    snap_read("R9 restart full count", 6);
    ticks(3);
    chk("R9 low again after restart", out, 0);
  endtask

  task automatic t_zero();
    wr(1'b1, 8'h00); load(16'd0); ticks(1);
    snap_read("R10 zero reads 0", 0);
    ticks(65535);
    chk("R10 not yet terminal", out, 0);
    ticks(1);
    chk("R10 terminal after 65536", out, 1);
  endtask

  task automatic t_snap();
    logic [7:0] b;
    wr(1'b1, 8'h00); load(16'h1234); ticks(1);
    wr(1'b1, 8'h80);
    chk("R11 rd_valid set", rd_valid, 1);
    chk("R11 mode untouched", out, 0);
    ticks(3);
    wr(1'b1, 8'h80);
    repeat (3) @(negedge clk);
    chk("R12 wr_ready high", wr_ready, 1);
    chk("R12 rd_data stable", rd_data, 8'h34);
    rd_byte(b); chk("R11 low byte first", b, 8'h34);
    rd_byte(b); chk("R11 high byte held", b, 8'h12);
    chk("R11 rd_valid clears", rd_valid, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_gate_hold();
    t_rate();
    t_rsv();
    t_rate1();
    t_square(5);
    t_square(4);
    t_gate23();
    t_snap();
    t_zero();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule